// File: doc/BRIEF.md
# Energy Pulse Width Limiter

This block shapes the energy pulse of a metering core before it leaves the chip on a test output. An upstream calculator raises a pulse request that is only meaningful on update ticks. The limiter samples that request on each tick. A request that was low on the previous tick and is high on this one starts a new pulse. The pulse can be cut short after a programmable number of update ticks, so a stuck or very long request cannot hold the meter's test output active indefinitely.

The maximum active time is 2·W+1 update ticks, where W is an 8-bit width code. The all-ones code turns the limit off, and the pulse then follows the request. A polarity bit selects an active-low pulse (the default, bit clear) or an active-high pulse (bit set). The registered pulse can be steered to a general-purpose pin, which gets its own output enable, and to the optical transmitter. Each destination has its own enable bit. A destination that is not selected sits at the inactive level.

Top module: `pwl_pulse_limiter`

## Requirements
- R1: While `rst_n` is low, every rising clock edge drives `pulse_o`, `gpio_o` and `opt_tx_o` to the inactive level (the complement of `invert_i`) and drives `gpio_oe_o` to 0.
- R2: A clock edge with `tick_i`=1 and `req_i`=1, where `req_i` was 0 at the previous tick, makes the pulse active at that same edge.
- R3: With a width code W other than all ones, the pulse stays active for exactly 2·W+1 tick intervals. It goes inactive at the edge of the (2·W+1)-th tick after the starting tick, counting only ticks at which `req_i` stays high.
- R4: After the width limit has been reached, the pulse stays inactive for as long as `req_i` stays high at each tick.
- R5: With the width code all ones (255), the pulse stays active for as long as `req_i` is high at each tick, with no upper bound.
- R6: A tick with `req_i`=0 ends an active pulse at that edge, before the limit is reached.
- R7: With `invert_i`=0 the active level is 0 and the idle level is 1. With `invert_i`=1 the active level is 1 and the idle level is 0. A change of `invert_i` reaches the output at the next clock edge.
- R8: Changes of `req_i` between ticks have no effect. Only the value of `req_i` at a clock edge with `tick_i`=1 is used.
- R9: `route_gpio_i`=1 gives `gpio_oe_o`=1 with `gpio_o` equal to the pulse level. `route_gpio_i`=0 gives `gpio_oe_o`=0 with `gpio_o` at the idle level. `route_opt_i`=1 puts the pulse level on `opt_tx_o`. `route_opt_i`=0 holds `opt_tx_o` at the idle level. Each change of a route bit takes effect at the next clock edge.
- R10: Every new request edge restarts the width count, so a pulse that follows a truncated or released pulse again gets the full 2·W+1 tick intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Update tick strobe, one clock wide |
| req_i | input | 1 | Pulse request, sampled on ticks |
| max_width_i | input | 8 | Width code W; the limit is 2·W+1 ticks; 255 turns the limit off |
| invert_i | input | 1 | 0: active-low pulse, 1: active-high pulse |
| route_gpio_i | input | 1 | Steer the pulse to the general-purpose pin |
| route_opt_i | input | 1 | Steer the pulse to the optical transmitter |
| pulse_o | output | 1 | Registered pulse level |
| gpio_oe_o | output | 1 | Output enable for the general-purpose pin |
| gpio_o | output | 1 | Pulse level for the general-purpose pin |
| opt_tx_o | output | 1 | Pulse level for the optical transmitter |

## Verification
A wrong width count shows up at the pin as a pulse that ends one or more tick intervals early or late. The bench therefore checks the output after every tick of a pulse, and this error is caught at the first tick where the count is off. A stale copy of the sampled request shows up at the next tick, either as a missed pulse start or as a pulse that restarts when it should not. Polarity and routing state are registered once, so an error there appears at the output one clock after the control input changes, and it is checked in both the idle and the active state.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

   typedef struct packed {
      logic gpio;
      logic opt;
   } pwl_route_t;

   function automatic logic pwl_drive(input logic on, input logic act_high);
      return on ? act_high : ~act_high;
   endfunction

endpackage

// File: rtl/pwl_req_edge.sv
module pwl_req_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic req_i,
   output logic new_edge_o
);

   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else if (tick_i)
         seen_q <= req_i;
   end

   assign new_edge_o = tick_i & req_i & ~seen_q;

   // R8: the sampled request only moves on a tick
   a_r8_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(tick_i)) |-> $stable(seen_q));

endmodule

// File: rtl/pwl_width_ctr.sv
module pwl_width_ctr #(
   parameter int W_BITS   = 8,
   parameter bit LIMIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              req_i,
   input  logic              new_edge_i,
   input  logic [W_BITS-1:0] width_i,
   output logic              active_nxt_o,
   output logic              active_o
);

   localparam int CNT_W = W_BITS + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [W_BITS-1:0] CODE_OFF = '1;

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             active_q, active_nxt;
   logic [CNT_W-1:0] nmax;
   logic             lim_on;
   logic             at_limit;

   assign nmax = {width_i, 1'b1};

   generate
      if (LIMIT_EN) begin : g_limit
         assign lim_on = (width_i != CODE_OFF);
      end else begin : g_nolimit
         assign lim_on = 1'b0;
      end
   endgenerate

   assign at_limit = lim_on && (cnt_q >= nmax);

   always_comb begin
      active_nxt = active_q;
      cnt_nxt    = cnt_q;
      if (tick_i) begin
         if (!req_i) begin
            active_nxt = 1'b0;
            cnt_nxt    = '0;
         end else if (new_edge_i) begin
            active_nxt = 1'b1;
            cnt_nxt    = CNT_ONE;
         end else if (active_q) begin
            if (at_limit)
               active_nxt = 1'b0;
            else if (cnt_q != CNT_MAX)
               cnt_nxt = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         active_q <= active_nxt;
         cnt_q    <= cnt_nxt;
      end
   end

   assign active_nxt_o = active_nxt;
   assign active_o     = active_q;

   // R3: once the limit is reached with the request still held, the pulse drops
   a_r3_truncate: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && req_i && !new_edge_i && active_q && lim_on && cnt_q >= nmax) |=> !active_q);

   // R4: the pulse only begins on a fresh request edge
   a_r4_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(active_q)) |-> $past(new_edge_i));

   // R5: with the limit off a held request keeps the pulse
   a_r5_unlimited: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && req_i && active_q && !lim_on) |=> active_q);

   // R6: a low request at a tick clears the pulse and the count
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !req_i) |=> (!active_q && cnt_q == '0));

endmodule

// File: rtl/pwl_out_stage.sv
module pwl_out_stage
   import pwl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_nxt_i,
   input  logic       invert_i,
   input  pwl_route_t route_i,
   output logic       pulse_o,
   output logic       gpio_oe_o,
   output logic       gpio_o,
   output logic       opt_tx_o
);

   logic lvl, idle;

   assign lvl  = pwl_drive(active_nxt_i, invert_i);
   assign idle = ~invert_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_o   <= idle;
         gpio_oe_o <= 1'b0;
         gpio_o    <= idle;
         opt_tx_o  <= idle;
      end else begin
         pulse_o   <= lvl;
         gpio_oe_o <= route_i.gpio;
         gpio_o    <= route_i.gpio ? lvl : idle;
         opt_tx_o  <= route_i.opt  ? lvl : idle;
      end
   end

   // R9: unrouted destinations sit idle
   a_r9_gpio_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(route_i.gpio)) |-> (!gpio_oe_o && gpio_o == ~$past(invert_i)));

   a_r9_opt_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(route_i.opt)) |-> (opt_tx_o == pulse_o));

endmodule

// File: rtl/pwl_pulse_limiter.sv
module pwl_pulse_limiter
   import pwl_pkg::*;
#(
   parameter int W_BITS   = 8,
   parameter bit LIMIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              req_i,
   input  logic [W_BITS-1:0] max_width_i,
   input  logic              invert_i,
   input  logic              route_gpio_i,
   input  logic              route_opt_i,
   output logic              pulse_o,
   output logic              gpio_oe_o,
   output logic              gpio_o,
   output logic              opt_tx_o
);

   generate
      if (W_BITS < 2 || W_BITS > 16) begin : g_bad_width
         $error("pwl_pulse_limiter: W_BITS must lie in 2..16");
      end
   endgenerate

   logic       new_edge;
   logic       act_nxt, act_q;
   pwl_route_t route;

   assign route.gpio = route_gpio_i;
   assign route.opt  = route_opt_i;

   pwl_req_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .req_i      (req_i),
      .new_edge_o (new_edge)
   );

   pwl_width_ctr #(.W_BITS(W_BITS), .LIMIT_EN(LIMIT_EN)) u_ctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .req_i        (req_i),
      .new_edge_i   (new_edge),
      .width_i      (max_width_i),
      .active_nxt_o (act_nxt),
      .active_o     (act_q)
   );

   pwl_out_stage u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_nxt_i (act_nxt),
      .invert_i     (invert_i),
      .route_i      (route),
      .pulse_o      (pulse_o),
      .gpio_oe_o    (gpio_oe_o),
      .gpio_o       (gpio_o),
      .opt_tx_o     (opt_tx_o)
   );

   // R7: the pin level matches the pulse state under the polarity of the last edge
   a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pulse_o == (act_q ? $past(invert_i) : ~$past(invert_i))));

endmodule

// File: tb/test_pwl_pulse_limiter.sv
module test_pwl_pulse_limiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       req = 1'b0;
   logic [7:0] wcode = 8'd2;
   logic       inv = 1'b0;
   logic       rg = 1'b1;
   logic       ro = 1'b1;
   logic       pulse_o, gpio_oe_o, gpio_o, opt_tx_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwl_pulse_limiter i_pwl_pulse_limiter (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .req_i(req),
      .max_width_i(wcode), .invert_i(inv), .route_gpio_i(rg), .route_opt_i(ro),
      .pulse_o(pulse_o), .gpio_oe_o(gpio_oe_o), .gpio_o(gpio_o), .opt_tx_o(opt_tx_o));

   function automatic logic lvl(input logic on);
      return on ? inv : ~inv;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic tk(input logic r);
      @(negedge clk);
      req  = r;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 pulse idle in reset", pulse_o, 1'b1);
      chk("R1 gpio_oe low in reset", gpio_oe_o, 1'b0);
      chk("R1 gpio idle in reset", gpio_o, 1'b1);
      chk("R1 opt idle in reset", opt_tx_o, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_limit();
      wcode = 8'd2;
      tk(1'b0);
      tk(1'b1);
      chk("R2 start on edge", pulse_o, lvl(1'b1));
      for (int i = 1; i < 5; i++) begin
         tk(1'b1);
         chk("R3 active within 2W+1", pulse_o, lvl(1'b1));
      end
      tk(1'b1);
      chk("R3 cut after 2W+1", pulse_o, lvl(1'b0));
      for (int i = 0; i < 3; i++) begin
         tk(1'b1);
         chk("R4 stays idle while held", pulse_o, lvl(1'b0));
      end
      tk(1'b0);
      chk("R4 idle after release", pulse_o, lvl(1'b0));
      tk(1'b1);
      chk("R10 restart active", pulse_o, lvl(1'b1));
      for (int i = 1; i < 5; i++) begin
         tk(1'b1);
         chk("R10 full width again", pulse_o, lvl(1'b1));
      end
      tk(1'b1);
      chk("R10 cut again at 2W+1", pulse_o, lvl(1'b0));
      tk(1'b0);
   endtask

   task automatic t_w0();
      wcode = 8'd0;
      tk(1'b0);
      tk(1'b1);
      chk("R3 W=0 one interval", pulse_o, lvl(1'b1));
      tk(1'b1);
      chk("R3 W=0 ends", pulse_o, lvl(1'b0));
      tk(1'b0);
   endtask

   task automatic t_unlimited();
      int bad = 0;
      wcode = 8'hFF;
      tk(1'b0);
      for (int i = 0; i < 600; i++) begin
         tk(1'b1);
         if (pulse_o !== lvl(1'b1)) bad++;
      end
      chk("R5 held 600 ticks", bad == 0, 1'b1);
      tk(1'b0);
      chk("R5 ends on release", pulse_o, lvl(1'b0));
   endtask

   task automatic t_early();
      wcode = 8'd10;
      tk(1'b0);
      tk(1'b1);
      tk(1'b1);
      tk(1'b1);
      chk("R6 active before release", pulse_o, lvl(1'b1));
      tk(1'b0);
      chk("R6 early release", pulse_o, lvl(1'b0));
   endtask

   task automatic t_between();
      wcode = 8'hFF;
      tk(1'b0);
      @(negedge clk) req = 1'b1;
      repeat (3) @(negedge clk);
      req = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 glitch between ticks ignored", pulse_o, lvl(1'b0));
      tk(1'b0);
      chk("R8 no pulse from missed glitch", pulse_o, lvl(1'b0));
      @(negedge clk) req = 1'b1;
      repeat (2) @(negedge clk);
      tk(1'b1);
      chk("R8 start at tick", pulse_o, lvl(1'b1));
      @(negedge clk) req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 drop between ticks ignored", pulse_o, lvl(1'b1));
      tk(1'b0);
      chk("R8 ends at tick", pulse_o, lvl(1'b0));
   endtask

   task automatic t_polarity();
      wcode = 8'd3;
      @(negedge clk) inv = 1'b1;
      @(negedge clk);
      chk("R7 idle low when inverted", pulse_o, 1'b0);
      tk(1'b1);
      chk("R7 active high when inverted", pulse_o, 1'b1);
      tk(1'b0);
      chk("R7 back to low", pulse_o, 1'b0);
      @(negedge clk) inv = 1'b0;
      @(negedge clk);
      chk("R7 idle high default", pulse_o, 1'b1);
      tk(1'b1);
      chk("R7 active low default", pulse_o, 1'b0);
      tk(1'b0);
   endtask

   task automatic t_route();
      wcode = 8'hFF;
      @(negedge clk) begin rg = 1'b0; ro = 1'b0; end
      @(negedge clk);
      chk("R9 oe off unrouted", gpio_oe_o, 1'b0);
      tk(1'b1);
      chk("R9 pulse active", pulse_o, 1'b0);
      chk("R9 gpio idle unrouted", gpio_o, 1'b1);
      chk("R9 opt idle unrouted", opt_tx_o, 1'b1);
      @(negedge clk) rg = 1'b1;
      @(negedge clk);
      chk("R9 oe on routed", gpio_oe_o, 1'b1);
      chk("R9 gpio carries pulse", gpio_o, 1'b0);
      chk("R9 opt still idle", opt_tx_o, 1'b1);
      @(negedge clk) ro = 1'b1;
      @(negedge clk);
      chk("R9 opt carries pulse", opt_tx_o, 1'b0);
      tk(1'b0);
      chk("R9 gpio follows idle", gpio_o, 1'b1);
      chk("R9 opt follows idle", opt_tx_o, 1'b1);
   endtask

   initial begin
      t_reset();
      t_limit();
      t_w0();
      t_unlimited();
      t_early();
      t_between();
      t_polarity();
      t_route();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule